// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit linear address into a 32-bit physical address. It reads translation entries from memory through a simple word-read port. Each request starts with a read of one entry in a 1024-entry directory that fills one 4 KB frame. The frame is named by a base register. That directory entry either maps a 4 MB page on its own, or points to a second 1024-entry table whose entries map 4 KB pages.

A 4 MB mapping is used only when the global large-page enable is 1 and the directory entry's size flag is 1. If either is 0, the walk goes on to the second-level table. An entry whose present bit is clear ends the walk with a fault. The walker takes one request at a time. It is busy from acceptance until it gives a single one-cycle response carrying the physical address, the page size, or a fault.

The read port uses a valid/ready handshake for the address. Read data comes back later on its own valid strobe. Memory may stall the address phase for any number of cycles.

Top module: `xlat_walker`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy_o`, `mem_rd_valid_o` and `rsp_valid_o` are 0.
- R2: A request is accepted when `req_valid_i` is 1 and `busy_o` is 0. `busy_o` is 1 from the next cycle through the response cycle. Requests presented while busy are ignored and cause no extra read or response.
- R3: The first read address is `{dir_base_i[31:12], lin[31:22], 2'b00}`, and bits 11:0 of the base are ignored. A read stays valid with a stable address until `mem_rd_ready_i` is 1.
- R4: Bit 0 of every entry is its present bit. A directory entry with bit 0 clear ends the walk after one read with `rsp_fault_o`=1, `rsp_big_o`=0 and `rsp_phys_o`=0.
- R5: When the large-page enable is 1 and directory entry bit 7 is 1, the walk ends after one read with `rsp_big_o`=1 and `rsp_phys_o`=`{entry[31:22], lin[21:0]}`. Entry bits 21:12 are ignored.
- R6: When the large-page enable is 0, a present directory entry with bit 7 set still points to a second-level table, and the walk makes two reads.
- R7: The second read address is `{dir_entry[31:12], lin[21:12], 2'b00}`. A present table entry gives `rsp_big_o`=0 and `rsp_phys_o`=`{table_entry[31:12], lin[11:0]}`.
- R8: A table entry with bit 0 clear ends the walk after two reads with `rsp_fault_o`=1, `rsp_big_o`=0 and `rsp_phys_o`=0.
- R9: `rsp_valid_o` is high for exactly one cycle per accepted request, and `busy_o` is 0 in the cycle after it.
- R10: `dir_base_i` and `big_page_en_i` are sampled at acceptance. Changing them during a walk has no effect on its reads or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_base_i | input | 32 | Directory frame base (bits 31:12 used) |
| big_page_en_i | input | 1 | Global enable for 4 MB mappings |
| req_valid_i | input | 1 | Translation request strobe |
| req_lin_i | input | 32 | Linear address to translate |
| busy_o | output | 1 | Walk in progress; new requests ignored |
| mem_rd_valid_o | output | 1 | Read address valid |
| mem_rd_ready_i | input | 1 | Memory takes the read address |
| mem_rd_addr_o | output | 32 | Word address of the entry |
| mem_rsp_valid_i | input | 1 | Read data valid strobe |
| mem_rsp_data_i | input | 32 | Entry read from memory |
| rsp_valid_o | output | 1 | One-cycle result strobe |
| rsp_fault_o | output | 1 | 1 = not-present fault |
| rsp_big_o | output | 1 | 1 = 4 MB page, 0 = 4 KB page |
| rsp_phys_o | output | 32 | Physical address (0 on fault) |

## Verification
The walk is tried with several kinds of linear address. Some hit a small-page directory entry under both enable settings, which shows the enable is irrelevant there. One hits a size-flagged entry with the enable set and then cleared, which separates the one-read large path from the two-read table path. Others hit missing entries at each level, which tells a first-level fault from a second-level fault by the read count. Extreme addresses at index 0 and 1023, a large entry with junk in bits 21:12, stalled address handshakes, requests held during a walk, and controls changed mid-walk show the ignored bits, the held read, the single response and the sampling point.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int ADDR_W      = 32;
    localparam int IDX_W       = 10;
    localparam int OFF_W       = 12;
    localparam int WORD_SHIFT  = 2;
    localparam int FRAME_W     = ADDR_W - OFF_W;
    localparam int BIG_OFF_W   = IDX_W + OFF_W;
    localparam int BIG_FRAME_W = ADDR_W - BIG_OFF_W;
    localparam int PRESENT_BIT = 0;
    localparam int PSIZE_BIT   = 7;

    typedef struct packed {
        logic [BIG_FRAME_W-1:0] dir_idx;
        logic [IDX_W-1:0]       tbl_idx;
        logic [OFF_W-1:0]       off;
    } lin_addr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic              fault;
        logic              big;
        logic [ADDR_W-1:0] phys;
    } walk_result_t;

    function automatic logic [ADDR_W-1:0] entry_addr(
        input logic [FRAME_W-1:0] frame,
        input logic [IDX_W-1:0]   idx
    );
        return {frame, idx, {WORD_SHIFT{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] small_phys(
        input logic [FRAME_W-1:0] frame,
        input lin_addr_t          lin
    );
        return {frame, lin.off};
    endfunction

    function automatic logic [ADDR_W-1:0] big_phys(
        input logic [FRAME_W-1:0] frame,
        input lin_addr_t          lin
    );
        return {frame[FRAME_W-1 -: BIG_FRAME_W], lin[BIG_OFF_W-1:0]};
    endfunction

endpackage

// File: rtl/xlat_entry_addr.sv
module xlat_entry_addr
    import xlat_pkg::*;
(
    input  logic                tbl_phase,
    input  logic [FRAME_W-1:0]  dir_frame,
    input  logic [FRAME_W-1:0]  tbl_frame,
    input  lin_addr_t           lin,
    output logic [ADDR_W-1:0]   rd_addr
);

    logic [ADDR_W-1:0] dir_addr;
    logic [ADDR_W-1:0] tbl_addr;

    always_comb begin
        dir_addr = entry_addr(dir_frame, lin.dir_idx);
        tbl_addr = entry_addr(tbl_frame, lin.tbl_idx);
        rd_addr  = tbl_phase ? tbl_addr : dir_addr;
    end

endmodule

// File: rtl/xlat_walk_fsm.sv
module xlat_walk_fsm
    import xlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_fire,
    input  logic        rd_ready,
    input  logic        rd_rsp_valid,
    input  logic        ent_present,
    input  logic        ent_large,
    output walk_state_e state_o,
    output logic        pde_we,
    output logic        result_we,
    output logic        result_fault,
    output logic        result_big
);

    walk_state_e state_q;
    walk_state_e state_d;

    always_comb begin
        state_d      = state_q;
        pde_we       = 1'b0;
        result_we    = 1'b0;
        result_fault = 1'b0;
        result_big   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_fire) state_d = ST_DIR_REQ;
            end
            ST_DIR_REQ: begin
                if (rd_ready) state_d = ST_DIR_WAIT;
            end
            ST_DIR_WAIT: begin
                if (rd_rsp_valid) begin
                    if (!ent_present) begin
                        result_we    = 1'b1;
                        result_fault = 1'b1;
                        state_d      = ST_DONE;
                    end else if (ent_large) begin
                        result_we  = 1'b1;
                        result_big = 1'b1;
                        state_d    = ST_DONE;
                    end else begin
                        pde_we  = 1'b1;
                        state_d = ST_TBL_REQ;
                    end
                end
            end
            ST_TBL_REQ: begin
                if (rd_ready) state_d = ST_TBL_WAIT;
            end
            ST_TBL_WAIT: begin
                if (rd_rsp_valid) begin
                    result_we    = 1'b1;
                    result_fault = !ent_present;
                    state_d      = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/xlat_result_reg.sv
module xlat_result_reg
    import xlat_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic               fault,
    input  logic               big,
    input  logic [FRAME_W-1:0] ent_frame,
    input  lin_addr_t          lin,
    output walk_result_t       res_o
);

    walk_result_t res_q;
    walk_result_t res_d;

    always_comb begin
        res_d.fault = fault;
        res_d.big   = big && !fault;
        if (fault)    res_d.phys = '0;
        else if (big) res_d.phys = big_phys(ent_frame, lin);
        else          res_d.phys = small_phys(ent_frame, lin);
    end

    always_ff @(posedge clk) begin
        if (rst)     res_q <= '0;
        else if (we) res_q <= res_d;
    end

    assign res_o = res_q;

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] dir_base_i,
    input  logic        big_page_en_i,
    input  logic        req_valid_i,
    input  logic [31:0] req_lin_i,
    output logic        busy_o,
    output logic        mem_rd_valid_o,
    input  logic        mem_rd_ready_i,
    output logic [31:0] mem_rd_addr_o,
    input  logic        mem_rsp_valid_i,
    input  logic [31:0] mem_rsp_data_i,
    output logic        rsp_valid_o,
    output logic        rsp_fault_o,
    output logic        rsp_big_o,
    output logic [31:0] rsp_phys_o
);

    walk_state_e        state;
    logic               req_fire;
    logic               pde_we;
    logic               result_we;
    logic               result_fault;
    logic               result_big;
    logic               ent_present;
    logic               ent_large;
    logic [FRAME_W-1:0] ent_frame;
    lin_addr_t          lin_q;
    logic [FRAME_W-1:0] base_frame_q;
    logic [FRAME_W-1:0] pde_frame_q;
    logic               big_en_q;
    walk_result_t       res;
    logic               unused_bits;

    assign unused_bits = ^{dir_base_i[OFF_W-1:0], mem_rsp_data_i[OFF_W-1:0]};

    assign req_fire    = req_valid_i && (state == ST_IDLE);
    assign ent_frame   = mem_rsp_data_i[ADDR_W-1:OFF_W];
    assign ent_present = mem_rsp_data_i[PRESENT_BIT];
    assign ent_large   = big_en_q && mem_rsp_data_i[PSIZE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            lin_q        <= '0;
            base_frame_q <= '0;
            big_en_q     <= 1'b0;
            pde_frame_q  <= '0;
        end else begin
            if (req_fire) begin
                lin_q        <= lin_addr_t'(req_lin_i);
                base_frame_q <= dir_base_i[ADDR_W-1:OFF_W];
                big_en_q     <= big_page_en_i;
            end
            if (pde_we) pde_frame_q <= ent_frame;
        end
    end

    xlat_walk_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req_fire     (req_fire),
        .rd_ready     (mem_rd_ready_i),
        .rd_rsp_valid (mem_rsp_valid_i),
        .ent_present  (ent_present),
        .ent_large    (ent_large),
        .state_o      (state),
        .pde_we       (pde_we),
        .result_we    (result_we),
        .result_fault (result_fault),
        .result_big   (result_big)
    );

    xlat_entry_addr u_addr (
        .tbl_phase (state == ST_TBL_REQ),
        .dir_frame (base_frame_q),
        .tbl_frame (pde_frame_q),
        .lin       (lin_q),
        .rd_addr   (mem_rd_addr_o)
    );

    xlat_result_reg u_res (
        .clk       (clk),
        .rst       (rst),
        .we        (result_we),
        .fault     (result_fault),
        .big       (result_big),
        .ent_frame (ent_frame),
        .lin       (lin_q),
        .res_o     (res)
    );

    assign busy_o         = (state != ST_IDLE);
    assign mem_rd_valid_o = (state == ST_DIR_REQ) || (state == ST_TBL_REQ);
    assign rsp_valid_o    = (state == ST_DONE);
    assign rsp_fault_o    = res.fault;
    assign rsp_big_o      = res.big;
    assign rsp_phys_o     = res.phys;

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid_i,
    input logic        busy_o,
    input logic        mem_rd_valid_o,
    input logic        mem_rd_ready_i,
    input logic [31:0] mem_rd_addr_o,
    input logic        rsp_valid_o,
    input logic        rsp_fault_o,
    input logic        rsp_big_o,
    input logic [31:0] rsp_phys_o
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!mem_rd_valid_o && !rsp_valid_o));

    assert_busy_from_req_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(req_valid_i));

    assert_read_held_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid_o && !mem_rd_ready_i) |=> (mem_rd_valid_o && $stable(mem_rd_addr_o)));

    assert_fault_clean_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && rsp_fault_o) |-> (!rsp_big_o && rsp_phys_o == 32'h0));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |=> (!rsp_valid_o && !busy_o));

endmodule

bind xlat_walker xlat_walker_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid_i    (req_valid_i),
    .busy_o         (busy_o),
    .mem_rd_valid_o (mem_rd_valid_o),
    .mem_rd_ready_i (mem_rd_ready_i),
    .mem_rd_addr_o  (mem_rd_addr_o),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_fault_o    (rsp_fault_o),
    .rsp_big_o      (rsp_big_o),
    .rsp_phys_o     (rsp_phys_o)
);

// File: tb/tb_xlat_walker.sv
`timescale 1ns/1ps
module tb_xlat_walker;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] dir_base_i;
    logic        big_page_en_i;
    logic        req_valid_i;
    logic [31:0] req_lin_i;
    logic        busy_o;
    logic        mem_rd_valid_o;
    logic        mem_rd_ready_i;
    logic [31:0] mem_rd_addr_o;
    logic        mem_rsp_valid_i;
    logic [31:0] mem_rsp_data_i;
    logic        rsp_valid_o;
    logic        rsp_fault_o;
    logic        rsp_big_o;
    logic [31:0] rsp_phys_o;

    always #2.5 clk = ~clk;

    xlat_walker dut (.*);

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    localparam logic [31:0] BASE = 32'h0001_0ABC;

    // {pse, lin, fault, big, phys, reads}
    localparam logic [68:0] VEC [0:11] = '{
        {1'b1, 32'h0040_5ABC, 1'b0, 1'b0, 32'h1234_5ABC, 2'd2},
        {1'b0, 32'h0040_5ABC, 1'b0, 1'b0, 32'h1234_5ABC, 2'd2},
        {1'b1, 32'h0040_6123, 1'b1, 1'b0, 32'h0000_0000, 2'd2},
        {1'b1, 32'h007F_FFFF, 1'b0, 1'b0, 32'hABCD_EFFF, 2'd2},
        {1'b1, 32'h0081_2345, 1'b0, 1'b1, 32'h4081_2345, 2'd1},
        {1'b0, 32'h0081_0345, 1'b0, 1'b0, 32'h0555_5345, 2'd2},
        {1'b1, 32'h00C0_0000, 1'b1, 1'b0, 32'h0000_0000, 2'd1},
        {1'b0, 32'h00C0_0ABC, 1'b1, 1'b0, 32'h0000_0000, 2'd1},
        {1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'hFFFF_FFFF, 2'd1},
        {1'b1, 32'h0080_0000, 1'b0, 1'b1, 32'h4080_0000, 2'd1},
        {1'b0, 32'h0080_0000, 1'b1, 1'b0, 32'h0000_0000, 2'd2},
        {1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0000_0000, 2'd2}
    };

    logic [31:0] mem [logic [31:0]];

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    // memory responder
    int          stall_n  = 0;
    int          wait_cnt = 0;
    int          n_reads  = 0;
    logic [31:0] rd_log [0:3];
    bit          pend = 0;
    logic [31:0] pend_addr;

    initial begin
        mem_rd_ready_i  = 1'b0;
        mem_rsp_valid_i = 1'b0;
        mem_rsp_data_i  = 32'hDEAD_BEEF;
        forever begin
            @(negedge clk);
            if (pend) begin
                mem_rsp_valid_i = 1'b1;
                mem_rsp_data_i  = mem_rd(pend_addr);
                pend = 0;
            end else begin
                mem_rsp_valid_i = 1'b0;
                mem_rsp_data_i  = 32'hDEAD_BEEF;
            end
            if (mem_rd_valid_o && !rst) begin
                if (wait_cnt < stall_n) begin
                    wait_cnt++;
                    mem_rd_ready_i = 1'b0;
                end else begin
                    wait_cnt = 0;
                    mem_rd_ready_i = 1'b1;
                    pend = 1;
                    pend_addr = mem_rd_addr_o;
                    if (n_reads < 4) rd_log[n_reads] = mem_rd_addr_o;
                    n_reads++;
                end
            end else begin
                mem_rd_ready_i = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    logic        got_fault, got_big;
    logic [31:0] got_phys;
    bit          got_ok;

    // hold: keep req_valid high with another address during the walk
    // alter: change base and enable after acceptance
    task automatic do_walk(input logic [31:0] lin, input bit pse,
                           input bit hold, input bit alter);
        @(negedge clk);
        n_reads       = 0;
        dir_base_i    = BASE;
        big_page_en_i = pse;
        req_lin_i     = lin;
        req_valid_i   = 1'b1;
        @(negedge clk);
        if (hold) req_lin_i = 32'h00C0_0000;
        else      req_valid_i = 1'b0;
        if (alter) begin
            big_page_en_i = ~pse;
            dir_base_i    = 32'h0005_0000;
        end
        got_ok = 0;
        for (int i = 0; i < 300; i++) begin
            if (rsp_valid_o) begin
                got_ok = 1;
                break;
            end
            @(negedge clk);
        end
        req_valid_i = 1'b0;
        got_fault = rsp_fault_o;
        got_big   = rsp_big_o;
        got_phys  = rsp_phys_o;
        check(got_ok, "R9", "response seen", {31'd0, got_ok}, 32'd1);
        @(negedge clk);
        check(!rsp_valid_o, "R9", "single pulse", {31'd0, rsp_valid_o}, 32'd0);
        check(!busy_o, "R9", "idle after response", {31'd0, busy_o}, 32'd0);
        dir_base_i    = BASE;
    endtask

    function automatic string vtag(input int i);
        case (i)
            0, 3:      return "R7";
            1, 5:      return "R6";
            2, 10, 11: return "R8";
            6, 7:      return "R4";
            default:   return "R5";
        endcase
    endfunction

    task automatic check_result(input logic [68:0] v, input string tag);
        logic [31:0] lin;
        logic [31:0] a0, a1, pde;
        lin = v[67:36];
        a0  = {BASE[31:12], lin[31:22], 2'b00};
        check(got_fault == v[35], tag, "fault", {31'd0, got_fault}, {31'd0, v[35]});
        check(got_big == v[34], tag, "size", {31'd0, got_big}, {31'd0, v[34]});
        check(got_phys == v[33:2], tag, "phys", got_phys, v[33:2]);
        check(n_reads == int'(v[1:0]), tag, "read count", n_reads, {30'd0, v[1:0]});
        check(rd_log[0] == a0, "R3", "directory address", rd_log[0], a0);
        if (v[1:0] == 2'd2 && n_reads >= 2) begin
            pde = mem_rd(a0);
            a1  = {pde[31:12], lin[21:12], 2'b00};
            check(rd_log[1] == a1, "R7", "table address", rd_log[1], a1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        mem[32'h0001_0004] = 32'h0002_0001;
        mem[32'h0001_0008] = 32'h4080_0081;
        mem[32'h0001_0FFC] = 32'hFFC3_F081;
        mem[32'h0002_0014] = 32'h1234_5001;
        mem[32'h0002_0018] = 32'h0000_7000;
        mem[32'h0002_0FFC] = 32'hABCD_E003;
        mem[32'h4080_0040] = 32'h0555_5001;

        rst           = 1'b1;
        dir_base_i    = BASE;
        big_page_en_i = 1'b0;
        req_valid_i   = 1'b0;
        req_lin_i     = 32'h0;
        repeat (3) @(negedge clk);
        check(!busy_o && !mem_rd_valid_o && !rsp_valid_o, "R1", "outputs in reset",
              {29'd0, busy_o, mem_rd_valid_o, rsp_valid_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !mem_rd_valid_o && !rsp_valid_o, "R1", "outputs after reset",
              {29'd0, busy_o, mem_rd_valid_o, rsp_valid_o}, 32'd0);

        for (int i = 0; i < 12; i++) begin
            do_walk(VEC[i][67:36], VEC[i][68], 0, 0);
            check_result(VEC[i], vtag(i));
        end

        // R2: request held high during the walk is ignored
        do_walk(VEC[0][67:36], VEC[0][68], 1, 0);
        check_result(VEC[0], "R2");

        // R10: controls changed after acceptance do not affect the walk
        do_walk(VEC[4][67:36], VEC[4][68], 0, 1);
        check_result(VEC[4], "R10");
        do_walk(VEC[5][67:36], VEC[5][68], 0, 1);
        check_result(VEC[5], "R10");

        // R3: stalled address handshakes
        stall_n = 3;
        do_walk(VEC[5][67:36], VEC[5][68], 0, 0);
        check_result(VEC[5], "R3");
        do_walk(VEC[8][67:36], VEC[8][68], 0, 0);
        check_result(VEC[8], "R3");
        stall_n = 0;

        // R2: no stray activity while idle
        repeat (4) @(negedge clk);
        check(!busy_o && !rsp_valid_o && !mem_rd_valid_o, "R2", "idle stays quiet",
              {29'd0, busy_o, mem_rd_valid_o, rsp_valid_o}, 32'd0);

        finished = 1;
        summary();
        $finish;
    end

endmodule